// File: doc/BRIEF.md
# Converter Reference Power Sequencer

This block sets the power state of a data converter's on-chip voltage reference and of the buffer that drives it. A two-bit power-down field from the configuration logic selects what is switched off when the chip select is released. A later bus event wakes the reference and buffer again. Which event does this depends on the interface mode: in serial-port mode it is the chip select being asserted again. In DSP mode it is one edge of a frame signal, and the power-down code decides which edge. The block drives an enable for the reference and an enable for the buffer. It also drives a ready flag that marks the reference as usable. After the internal reference has been fully off, ready stays low for a settling interval that is set as a number of clock cycles.

Chip select (active low) and the frame signal are brought into the clock domain through two flip-flops each. A third register is used for edge detection. The power-down field is sampled only in the cycle in which a chip-select release is detected. The controller has five states:

- ST_SETTLE: reference and buffer on, settle counter running, ready low.
- ST_ON: everything on, ready high.
- ST_OFF_ALL: full shutdown, code 01.
- ST_OFF_BUF: reference on, buffer off, code 10.
- ST_EXTREF: both off for an external reference, code 11, ready high.

The transitions are:

- T_SETTLED: ST_SETTLE to ST_ON when the counter expires.
- T_APPLY: on a chip-select release, go to the state the field selects.
- T_WAKE_FULL: ST_OFF_ALL to ST_SETTLE.
- T_WAKE_BUF: ST_OFF_BUF to ST_ON.
- T_ABORT: T_APPLY with code 01 or 11 while settling.

Reset enters ST_SETTLE.

Top module: `refpwr_ctrl`

## Requirements
- R1: The power-down field is decoded as follows: 00 = stay on, 01 = full off, 10 = buffer off, 11 = external reference. With code 00, a chip-select release from ST_ON keeps ref_en_o, buf_en_o and ready_o at 1. Chip-select assertion while on changes nothing.
- R2: Code 01 applied at a chip-select release drives ref_en_o=0, buf_en_o=0 and ready_o=0.
- R3: Code 10 applied at a chip-select release from a settled reference drives ref_en_o=1, buf_en_o=0 and ready_o=0.
- R4: Code 11 applied at a chip-select release drives ref_en_o=0, buf_en_o=0 and ready_o=1. Chip-select assertion does not leave this state. A release with code 00 or 10 enters ST_SETTLE.
- R5: In serial-port mode (dsp_sel_i=0), chip-select assertion wakes both power-down states. From code 01 it enters ST_SETTLE (outputs 1,1,0). From code 10 it goes straight to ST_ON (outputs 1,1,1). Frame edges are ignored in this mode.
- R6: In DSP mode (dsp_sel_i=1), code 01 wakes on a falling frame edge and code 10 wakes on a rising frame edge. The opposite frame edge and chip-select assertion are ignored.
- R7: After ST_SETTLE is entered, whether from reset, from a wake or from ST_EXTREF, ready_o stays 0 for exactly SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US clock cycles. It rises in the next cycle, with ref_en_o=buf_en_o=1 throughout.
- R8: The power-down field has an effect only in the cycle in which a chip-select release is detected. The value present then is the one applied.
- R9: Code 10 applied while settling leaves the block in ST_SETTLE, and the settle count is not restarted.
- R10: Code 01 applied while settling aborts the settle and enters ST_OFF_ALL.
- R11: In DSP mode, a chip-select release in a power-down state applies the field again. Code 00 from ST_OFF_BUF goes to ST_ON at once. Code 00 from ST_OFF_ALL goes to ST_SETTLE.
- R12: A change on cs_n_i or frame_i reaches the outputs exactly three clock edges later: two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_mode_i | input | 2 | Power-down field (00 on, 01 full off, 10 buffer off, 11 external) |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| frame_i | input | 1 | DSP frame signal, asynchronous |
| dsp_sel_i | input | 1 | 1 = DSP mode, 0 = serial-port mode |
| ref_en_o | output | 1 | Internal reference enable |
| buf_en_o | output | 1 | Reference buffer enable |
| ready_o | output | 1 | Reference usable |

## Verification
Every pin change on cs_n_i or frame_i is driven on a falling clock edge. The outputs it causes are due after the third rising edge that follows. The bench therefore waits three rising edges and samples on the next falling edge. Settling results are due SETTLE_CYC cycles after the sample at which ST_SETTLE was first seen. The bench counts SETTLE_CYC-1 edges and expects ready still low, then one more edge and expects it high, so an off-by-one counter is caught. Ignored events are checked at the same three-edge point, where any wrongly taken transition would already be visible.

// File: rtl/refpwr_pkg.sv
package refpwr_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_ON,
        ST_OFF_ALL,
        ST_OFF_BUF,
        ST_EXTREF
    } pwr_state_e;

    localparam logic [1:0] PD_ON   = 2'b00;
    localparam logic [1:0] PD_FULL = 2'b01;
    localparam logic [1:0] PD_BUF  = 2'b10;
    localparam logic [1:0] PD_EXT  = 2'b11;

    // Target state of a chip-select release (T_APPLY)
    function automatic pwr_state_e apply_code(input logic [1:0] code, input logic ref_valid);
        pwr_state_e t;
        unique case (code)
            PD_ON:   t = ref_valid ? ST_ON : ST_SETTLE;
            PD_FULL: t = ST_OFF_ALL;
            PD_BUF:  t = ref_valid ? ST_OFF_BUF : ST_SETTLE;
            default: t = ST_EXTREF;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/refpwr_sync.sv
module refpwr_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= RST_VAL[i];
                sync_q[i] <= RST_VAL[i];
                prev_q[i] <= RST_VAL[i];
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/refpwr_timer.sv
module refpwr_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/refpwr_fsm.sv
module refpwr_fsm
    import refpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pd_mode_i,
    input  logic       dsp_sel_i,
    input  logic       cs_rise_i,
    input  logic       cs_fall_i,
    input  logic       fr_rise_i,
    input  logic       fr_fall_i,
    input  logic       tmr_done_i,
    output logic       settling_o,
    output logic       ref_en_o,
    output logic       buf_en_o,
    output logic       ready_o
);
    pwr_state_e state_q, state_d, target;
    logic wake_full, wake_buf;

    assign wake_full = dsp_sel_i ? fr_fall_i : cs_fall_i;
    assign wake_buf  = dsp_sel_i ? fr_rise_i : cs_fall_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SETTLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        target  = apply_code(pd_mode_i, (state_q == ST_ON) || (state_q == ST_OFF_BUF));
        unique case (state_q)
            ST_SETTLE: begin
                if (cs_rise_i)
                    state_d = (target == ST_SETTLE && tmr_done_i) ? ST_ON : target;
                else if (tmr_done_i)
                    state_d = ST_ON;                        // T_SETTLED
            end
            ST_ON: if (cs_rise_i) state_d = target;         // T_APPLY
            ST_OFF_ALL: begin
                if (wake_full)      state_d = ST_SETTLE;    // T_WAKE_FULL
                else if (cs_rise_i) state_d = target;
            end
            ST_OFF_BUF: begin
                if (wake_buf)       state_d = ST_ON;        // T_WAKE_BUF
                else if (cs_rise_i) state_d = target;
            end
            ST_EXTREF: if (cs_rise_i) state_d = target;
            default: state_d = ST_SETTLE;
        endcase
    end

    always_comb begin
        settling_o = 1'b0;
        ref_en_o   = 1'b0;
        buf_en_o   = 1'b0;
        ready_o    = 1'b0;
        unique case (state_q)
            ST_SETTLE:  begin ref_en_o = 1'b1; buf_en_o = 1'b1; settling_o = 1'b1; end
            ST_ON:      begin ref_en_o = 1'b1; buf_en_o = 1'b1; ready_o = 1'b1; end
            ST_OFF_ALL: ;
            ST_OFF_BUF: ref_en_o = 1'b1;
            ST_EXTREF:  ready_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/refpwr_ctrl.sv
module refpwr_ctrl #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pd_mode_i,
    input  logic       cs_n_i,
    input  logic       frame_i,
    input  logic       dsp_sel_i,
    output logic       ref_en_o,
    output logic       buf_en_o,
    output logic       ready_o
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic [1:0] rise_v, fall_v;
    logic cs_rise, cs_fall, fr_rise, fr_fall;
    logic settling, tmr_done;

    // bit 0: chip select (idle high), bit 1: frame (idle low)
    refpwr_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({frame_i, cs_n_i}),
        .rise_o(rise_v), .fall_o(fall_v)
    );

    assign cs_rise = rise_v[0];
    assign cs_fall = fall_v[0];
    assign fr_rise = rise_v[1];
    assign fr_fall = fall_v[1];

    refpwr_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(settling), .done_o(tmr_done)
    );

    refpwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pd_mode_i(pd_mode_i), .dsp_sel_i(dsp_sel_i),
        .cs_rise_i(cs_rise), .cs_fall_i(cs_fall),
        .fr_rise_i(fr_rise), .fr_fall_i(fr_fall),
        .tmr_done_i(tmr_done), .settling_o(settling),
        .ref_en_o(ref_en_o), .buf_en_o(buf_en_o), .ready_o(ready_o)
    );
endmodule

// File: rtl/refpwr_ctrl_chk.sv
module refpwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dsp_sel_i,
    input logic [1:0] pd_mode_i,
    input logic       cs_rise,
    input logic       cs_fall,
    input logic       fr_rise,
    input logic       fr_fall,
    input logic       tmr_done,
    input logic       ref_en_o,
    input logic       buf_en_o,
    input logic       ready_o
);
    // R3
    buf_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en_o |-> ref_en_o);

    // R2
    full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && pd_mode_i == 2'b01 && !fr_rise && !fr_fall |=> !ref_en_o && !buf_en_o);

    // R4
    ext_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && pd_mode_i == 2'b11 && !fr_rise && !fr_fall |=> ready_o && !ref_en_o && !buf_en_o);

    // R5
    serial_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_sel_i && cs_fall && !ref_en_o && !ready_o |=> ref_en_o && buf_en_o && !ready_o);

    // R7
    ready_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) && ref_en_o |-> $past(ref_en_o));

    // R8
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise && !cs_fall && !fr_rise && !fr_fall && !tmr_done
        |=> $stable({ref_en_o, buf_en_o, ready_o}));
endmodule

bind refpwr_ctrl refpwr_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dsp_sel_i(dsp_sel_i), .pd_mode_i(pd_mode_i),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .fr_rise(fr_rise), .fr_fall(fr_fall),
    .tmr_done(tmr_done), .ref_en_o(ref_en_o), .buf_en_o(buf_en_o), .ready_o(ready_o)
);

// File: tb/refpwr_ctrl_bench.sv
`timescale 1ns/1ps
module refpwr_ctrl_bench;
    localparam int CLK_HZ = 50_000_000;
    localparam int SET_US = 1;
    localparam int N      = (CLK_HZ / 1_000_000) * SET_US;   // settle cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pd = 2'b00;
    logic cs_n = 1'b1;
    logic frame = 1'b0;
    logic dsp = 1'b0;
    logic ref_en, buf_en, rdy;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    refpwr_ctrl #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US)) u_refpwr_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_mode_i(pd), .cs_n_i(cs_n), .frame_i(frame),
        .dsp_sel_i(dsp), .ref_en_o(ref_en), .buf_en_o(buf_en), .ready_o(rdy)
    );

    task automatic chk(input logic r, input logic b, input logic y, input string tag);
        checks++;
        if ({ref_en, buf_en, rdy} !== {r, b, y}) begin
            errors++;
            $display("FAIL %s: got ref=%b buf=%b rdy=%b expected ref=%b buf=%b rdy=%b",
                     tag, ref_en, buf_en, rdy, r, b, y);
        end
    endtask

    // R12: three edges to reach the outputs, sampled on the next falling edge
    task automatic lat3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cs_to(input logic v);
        cs_n = v;
        lat3();
    endtask

    task automatic fr_to(input logic v);
        frame = v;
        lat3();
    endtask

    // called right after the sample where ST_SETTLE is first seen
    task automatic settle_done(input string tag);
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        chk(1, 1, 0, tag);
        @(posedge clk);
        @(negedge clk);
        chk(1, 1, 1, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(1, 1, 0, "R7 reset settling");
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        chk(1, 1, 0, "R7 reset last settle cycle");
        @(posedge clk);
        @(negedge clk);
        chk(1, 1, 1, "R7 reset ready");

        for (int d = 0; d < 2; d++) begin
            dsp = d[0];
            // code 00
            pd = 2'b00;
            cs_to(0); chk(1, 1, 1, "R1 assert while on");
            cs_to(1); chk(1, 1, 1, "R1 release code 00");
            // code 01
            cs_to(0); pd = 2'b01;
            cs_to(1); chk(0, 0, 0, "R2 full off");
            if (d == 1) begin
                fr_to(1); chk(0, 0, 0, "R6 rising frame ignored for 01");
                cs_to(0); chk(0, 0, 0, "R6 chip select ignored in dsp");
                cs_to(1); chk(0, 0, 0, "R11 reapply 01");
                fr_to(0); chk(1, 1, 0, "R6 falling frame wakes 01");
            end else begin
                fr_to(1); chk(0, 0, 0, "R5 frame rise ignored serial");
                fr_to(0); chk(0, 0, 0, "R5 frame fall ignored serial");
                cs_to(0); chk(1, 1, 0, "R5 wake 01 to settle");
            end
            settle_done("R7 settle after wake");
            pd = 2'b00;
            if (cs_n == 1'b0) cs_to(1);
            // code 10
            cs_to(0); pd = 2'b10;
            if (d == 1) fr_to(1);
            cs_to(1); chk(1, 0, 0, "R3 buffer off");
            if (d == 1) begin
                fr_to(0); chk(1, 0, 0, "R6 falling frame ignored for 10");
                fr_to(1); chk(1, 1, 1, "R6 rising frame wakes 10");
                fr_to(0); chk(1, 1, 1, "R6 frame after wake");
            end else begin
                cs_to(0); chk(1, 1, 1, "R5 wake 10 immediate");
                pd = 2'b00;
                cs_to(1);
            end
            pd = 2'b00;
            // code 11
            cs_to(0); pd = 2'b11;
            cs_to(1); chk(0, 0, 1, "R4 external reference");
            cs_to(0); chk(0, 0, 1, "R4 assert keeps external");
            pd = 2'b00;
            cs_to(1); chk(1, 1, 0, "R4 leave external to settle");
            settle_done("R7 settle after external");
        end

        // R8: field only applied at release, last value wins
        dsp = 1'b0;
        cs_to(0); pd = 2'b01;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(1, 1, 1, "R8 field ignored before release");
        pd = 2'b00;
        cs_to(1); chk(1, 1, 1, "R8 value at release applied");

        // R9: code 10 while settling does not restart the count
        cs_to(0); pd = 2'b01;
        cs_to(1); chk(0, 0, 0, "R9 prep full off");
        cs_to(0); chk(1, 1, 0, "R9 settling");
        pd = 2'b10;
        cs_to(1); chk(1, 1, 0, "R9 code 10 keeps settle");
        repeat (N - 4) @(posedge clk);
        @(negedge clk);
        chk(1, 1, 0, "R9 last settle cycle");
        @(posedge clk);
        @(negedge clk);
        chk(1, 1, 1, "R9 count not restarted");
        pd = 2'b00;

        // R10: code 01 while settling aborts
        cs_to(0); pd = 2'b01;
        cs_to(1);
        cs_to(0); chk(1, 1, 0, "R10 settling");
        cs_to(1); chk(0, 0, 0, "R10 abort to full off");
        cs_to(0); chk(1, 1, 0, "R10 wake again");
        settle_done("R10 settle completes");
        pd = 2'b00;
        cs_to(1);

        // R11: dsp reapply from power-down states
        dsp = 1'b1;
        cs_to(0); pd = 2'b10;
        cs_to(1); chk(1, 0, 0, "R11 buffer off");
        cs_to(0); pd = 2'b00;
        cs_to(1); chk(1, 1, 1, "R11 00 from buffer off");
        cs_to(0); pd = 2'b01;
        cs_to(1); chk(0, 0, 0, "R11 full off");
        cs_to(0); pd = 2'b00;
        cs_to(1); chk(1, 1, 0, "R11 00 from full off settles");
        settle_done("R11 settle completes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule